// File: doc/BRIEF.md
# User IPI Posting Engine

This block turns one user-level interprocessor-interrupt request into its full posting sequence. A command carries a target-table index. The engine first checks the index against the table limit. It then reads the 16-byte table slot over a simple 64-bit memory port and validates it. Next it takes the memory lock and performs a read-modify-write of the 128-bit posted-interrupt descriptor that the slot points to. In that step it sets the pending bit for the slot's user vector. When neither the suppress flag nor the outstanding flag was already set, it marks a notification as outstanding. After the lock is released, it emits an ordinary IPI request toward the interrupt controller.

The memory port is treated as atomic while `mem_lock` is high. Every memory access is a word transfer that completes when `mem_req` and `mem_ready` are both high at a clock edge, and read data is taken in that same cycle. The controller is modelled as a request/acknowledge pair. `busy` stays high from the moment a command is accepted until its single-cycle `done` or `fault` pulse.

The state machine has these states. IDLE accepts a command. It moves to FAULT when the index is out of range, and to SLOT_LO otherwise. SLOT_LO and SLOT_HI read the two slot words. SLOT_HI moves to FAULT on a bad slot and to DSC_LO_RD otherwise. DSC_LO_RD is a locked read, and it moves to FAULT on reserved bits and to DSC_HI_RD otherwise. DSC_HI_RD is a locked read, followed by DSC_HI_WR and then DSC_LO_WR, both locked writes. DSC_LO_WR moves to NOTIFY when a notification is owed and to FINISH otherwise. NOTIFY moves to FINISH on acknowledge. FINISH (done pulse) and FAULT (fault pulse) both return to IDLE.

Top module: `uipi_post_engine`

## Requirements
- R1: While reset is held and right after it, `busy`, `mem_req`, `mem_lock`, `ipi_req`, `done` and `fault` are all 0.
- R2: An index strictly greater than `tbl_size` gives a `fault` pulse in the cycle after acceptance, with no memory access. An index equal to `tbl_size` is accepted normally.
- R3: The slot is read as two unlocked word reads. The first is at `tbl_base + index*16` and the second is at that address plus 8.
- R4: The slot's low word must have bit 0 set and bits 7:1 clear. Otherwise the engine raises `fault` after the two slot reads, without touching the descriptor.
- R5: The descriptor's low word is read with `mem_lock` high, at the address held in the slot's high word. If its bits 15:2 or 31:24 are nonzero, the engine raises `fault` after that single read, drops the lock and writes nothing.
- R6: The pending bitmap is the descriptor word at its address plus 8. It is read and written back under lock with bit `uv` set, where `uv` is slot low-word bits 13:8.
- R7: If descriptor bit 1 (suppress) and bit 0 (outstanding) are both 0, the low word is written back with bit 0 set and one notification follows. Otherwise the low word is written back unchanged and no notification is sent.
- R8: The lock is released before `ipi_req` rises. `ipi_req` and its payload are held until `ipi_ack`.
- R9: `ipi_vector` is descriptor bits 23:16. With `apic_x2_mode` = 1 at acceptance, `ipi_dest` is descriptor bits 63:32. Otherwise it is descriptor bits 47:40, zero-extended.
- R10: `busy` is high from the cycle after acceptance through the `done` or `fault` pulse, and low in the cycle after that pulse. The pulses are one cycle long and never coincide. `cmd_valid` is ignored while busy.
- R11: While `mem_req` is high and `mem_ready` is low, the address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a posting request (taken when not busy) |
| cmd_index | input | 64 | Target-table index |
| tbl_base | input | 64 | Byte address of table slot 0 |
| tbl_size | input | 64 | Highest legal index |
| apic_x2_mode | input | 1 | 1 = 32-bit destination format, 0 = 8-bit |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: sequence completed |
| fault | output | 1 | One-cycle pulse: general-protection fault, error code 0 |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Memory held atomic while high |
| mem_addr | output | 64 | Byte address of the word |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ready` |
| ipi_req | output | 1 | Notification request |
| ipi_vector | output | 8 | Notification vector |
| ipi_dest | output | 32 | Destination ID |
| ipi_ack | input | 1 | Controller takes the request |

## Verification
The fault for an out-of-range index is due exactly one cycle after acceptance. Every other result depends on how many cycles `mem_ready` and `ipi_ack` take, because both are driven randomly. For that reason the bench does not count a fixed latency for them. It samples on the falling edge, waits for the `done` or `fault` pulse with a cycle limit, and then compares the logged sequence of completed memory transfers, the final memory image and the logged notification with values its own model computed beforehand. The `busy` level is checked in the first cycle after acceptance and in the first cycle after the pulse.

// File: rtl/uipi_pkg.sv
package uipi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SLOT_LO,
        ST_SLOT_HI,
        ST_DSC_LO_RD,
        ST_DSC_HI_RD,
        ST_DSC_HI_WR,
        ST_DSC_LO_WR,
        ST_NOTIFY,
        ST_FINISH,
        ST_FAULT
    } post_state_e;

    // descriptor low-word field positions (decoded by software and by the controller)
    localparam int OUTST_BIT   = 0;
    localparam int SUPPR_BIT   = 1;
    localparam int RSV0_LSB    = 2;
    localparam int RSV0_MSB    = 15;
    localparam int NVEC_LSB    = 16;
    localparam int RSV1_LSB    = 24;
    localparam int RSV1_MSB    = 31;
    localparam int DEST_LSB    = 32;
    localparam int XDEST_LSB   = 40;
    localparam int XDEST_W     = 8;

    // slot low-word field positions
    localparam int SLOT_CTL_W  = 8;
    localparam int SLOT_UV_LSB = 8;

endpackage

// File: rtl/uipi_index_gate.sv
module uipi_index_gate #(
    parameter int ADDR_W     = 64,
    parameter int IDX_W      = 64,
    parameter int SLOT_SHIFT = 4
) (
    input  logic [IDX_W-1:0]  index,
    input  logic [IDX_W-1:0]  limit,
    input  logic [ADDR_W-1:0] base,
    output logic              out_of_range,
    output logic [ADDR_W-1:0] slot_addr
);
    assign out_of_range = (index > limit);
    assign slot_addr    = base + (ADDR_W'(index) << SLOT_SHIFT);
endmodule

// File: rtl/uipi_slot_check.sv
module uipi_slot_check
    import uipi_pkg::*;
(
    input  logic [SLOT_CTL_W-1:0] ctl,
    output logic                  slot_ok
);
    // bit 0 is the valid flag, the remaining control bits are reserved
    assign slot_ok = ctl[0] && (ctl[SLOT_CTL_W-1:1] == '0);
endmodule

// File: rtl/uipi_desc_merge.sv
module uipi_desc_merge
    import uipi_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int UV_W   = 6,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 32
) (
    input  logic [WORD_W-1:0] dsc_lo,
    input  logic [WORD_W-1:0] dsc_pend,
    input  logic [UV_W-1:0]   user_vec,
    input  logic              x2_mode,
    output logic              desc_ok,
    output logic              need_notify,
    output logic [WORD_W-1:0] lo_next,
    output logic [WORD_W-1:0] pend_next,
    output logic [VEC_W-1:0]  notify_vec,
    output logic [DEST_W-1:0] notify_dest
);
    assign desc_ok     = (dsc_lo[RSV0_MSB:RSV0_LSB] == '0) && (dsc_lo[RSV1_MSB:RSV1_LSB] == '0);
    assign need_notify = !dsc_lo[SUPPR_BIT] && !dsc_lo[OUTST_BIT];
    assign lo_next     = dsc_lo | (WORD_W'(need_notify) << OUTST_BIT);
    assign pend_next   = dsc_pend | (WORD_W'(1) << user_vec);
    assign notify_vec  = dsc_lo[NVEC_LSB +: VEC_W];

    generate
        if (DEST_W > XDEST_W) begin : g_wide_dest
            assign notify_dest = x2_mode ? dsc_lo[DEST_LSB +: DEST_W]
                                         : {{(DEST_W-XDEST_W){1'b0}}, dsc_lo[XDEST_LSB +: XDEST_W]};
        end else begin : g_narrow_dest
            assign notify_dest = x2_mode ? dsc_lo[DEST_LSB +: DEST_W]
                                         : dsc_lo[XDEST_LSB +: DEST_W];
        end
    endgenerate
endmodule

// File: rtl/uipi_post_engine.sv
module uipi_post_engine
    import uipi_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 64,
    parameter int WORD_W = 64,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [IDX_W-1:0]  tbl_size,
    input  logic              apic_x2_mode,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ipi_req,
    output logic [VEC_W-1:0]  ipi_vector,
    output logic [DEST_W-1:0] ipi_dest,
    input  logic              ipi_ack
);
    localparam int SLOT_SHIFT = 4;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int UV_W       = $clog2(WORD_W);

    post_state_e       state_q, state_d;
    logic [ADDR_W-1:0] slot_addr_q, dsc_addr_q;
    logic [SLOT_CTL_W-1:0] slot_ctl_q;
    logic [UV_W-1:0]   uv_q;
    logic [WORD_W-1:0] dsc_lo_q, dsc_pend_q;
    logic              x2_q;

    logic              oob;
    logic [ADDR_W-1:0] slot_addr_w;
    logic              slot_ok;
    logic [WORD_W-1:0] merge_lo;
    logic              desc_ok, need_notify;
    logic [WORD_W-1:0] lo_next, pend_next;
    logic [VEC_W-1:0]  nvec;
    logic [DEST_W-1:0] ndest;
    logic              xfer;

    uipi_index_gate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_SHIFT(SLOT_SHIFT)) u_gate (
        .index(cmd_index), .limit(tbl_size), .base(tbl_base),
        .out_of_range(oob), .slot_addr(slot_addr_w)
    );

    uipi_slot_check u_slot (.ctl(slot_ctl_q), .slot_ok(slot_ok));

    // the reserved-bit test sees the live read data so a bad descriptor faults on its first read
    assign merge_lo = (state_q == ST_DSC_LO_RD) ? mem_rdata : dsc_lo_q;

    uipi_desc_merge #(.WORD_W(WORD_W), .UV_W(UV_W), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_merge (
        .dsc_lo(merge_lo), .dsc_pend(dsc_pend_q), .user_vec(uv_q), .x2_mode(x2_q),
        .desc_ok(desc_ok), .need_notify(need_notify), .lo_next(lo_next),
        .pend_next(pend_next), .notify_vec(nvec), .notify_dest(ndest)
    );

    assign xfer = mem_req && mem_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cmd_valid) state_d = oob ? ST_FAULT : ST_SLOT_LO;
            ST_SLOT_LO:   if (mem_ready) state_d = ST_SLOT_HI;
            ST_SLOT_HI:   if (mem_ready) state_d = slot_ok ? ST_DSC_LO_RD : ST_FAULT;
            ST_DSC_LO_RD: if (mem_ready) state_d = desc_ok ? ST_DSC_HI_RD : ST_FAULT;
            ST_DSC_HI_RD: if (mem_ready) state_d = ST_DSC_HI_WR;
            ST_DSC_HI_WR: if (mem_ready) state_d = ST_DSC_LO_WR;
            ST_DSC_LO_WR: if (mem_ready) state_d = need_notify ? ST_NOTIFY : ST_FINISH;
            ST_NOTIFY:    if (ipi_ack)   state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            ST_FAULT:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            slot_addr_q <= '0;
            dsc_addr_q  <= '0;
            slot_ctl_q  <= '0;
            uv_q        <= '0;
            dsc_lo_q    <= '0;
            dsc_pend_q  <= '0;
            x2_q        <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                slot_addr_q <= slot_addr_w;
                x2_q        <= apic_x2_mode;
            end
            if (xfer) begin
                unique case (state_q)
                    ST_SLOT_LO: begin
                        slot_ctl_q <= mem_rdata[SLOT_CTL_W-1:0];
                        uv_q       <= mem_rdata[SLOT_UV_LSB +: UV_W];
                    end
                    ST_SLOT_HI:   dsc_addr_q <= mem_rdata[ADDR_W-1:0];
                    ST_DSC_LO_RD: dsc_lo_q   <= mem_rdata;
                    ST_DSC_HI_RD: dsc_pend_q <= mem_rdata;
                    default: ;
                endcase
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = 1'b0;
        fault      = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_lock   = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        ipi_req    = 1'b0;
        ipi_vector = '0;
        ipi_dest   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SLOT_LO: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr_q;
            end
            ST_SLOT_HI: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr_q + ADDR_W'(WORD_BYTES);
            end
            ST_DSC_LO_RD: begin
                mem_req  = 1'b1;
                mem_lock = 1'b1;
                mem_addr = dsc_addr_q;
            end
            ST_DSC_HI_RD: begin
                mem_req  = 1'b1;
                mem_lock = 1'b1;
                mem_addr = dsc_addr_q + ADDR_W'(WORD_BYTES);
            end
            ST_DSC_HI_WR: begin
                mem_req   = 1'b1;
                mem_lock  = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dsc_addr_q + ADDR_W'(WORD_BYTES);
                mem_wdata = pend_next;
            end
            ST_DSC_LO_WR: begin
                mem_req   = 1'b1;
                mem_lock  = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dsc_addr_q;
                mem_wdata = lo_next;
            end
            ST_NOTIFY: begin
                ipi_req    = 1'b1;
                ipi_vector = nvec;
                ipi_dest   = ndest;
            end
            ST_FINISH: done  = 1'b1;
            ST_FAULT:  fault = 1'b1;
            default: ;
        endcase
    end

    // R2: an out-of-range index faults on the next cycle
    p_oob_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_index > tbl_size)) |=> fault);

    // R6: writes to the descriptor only happen under lock
    p_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);

    // R8: lock is gone and memory idle while a notification is raised
    p_notify_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_req |-> (!mem_lock && !mem_req));

    // R8: the notification and its payload wait for the acknowledge
    p_ipi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_req && !ipi_ack) |=> (ipi_req && $stable(ipi_vector) && $stable(ipi_dest)));

    // R10: pulses are exclusive and end the busy window
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
    p_pulse_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !busy);

    // R11: a stalled memory request keeps its content
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: tb/uipi_post_engine_test.sv
module uipi_post_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [63:0] cmd_index = '0;
    logic [63:0] tbl_base = 64'h200;
    logic [63:0] tbl_size = 64'd5;
    logic        apic_x2_mode = 1'b0;
    logic        busy, done, fault;
    logic        mem_req, mem_we, mem_lock;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        ipi_req;
    logic [7:0]  ipi_vector;
    logic [31:0] ipi_dest;
    logic        ipi_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] bmem [0:255];
    int          log_n = 0;
    logic [63:0] log_addr [0:7];
    logic [63:0] log_data [0:7];
    logic        log_we   [0:7];
    logic        log_lock [0:7];
    int          ipi_n = 0;
    logic [7:0]  ipi_vec_seen;
    logic [31:0] ipi_dst_seen;
    logic        ipi_lock_seen;

    always #5 clk = ~clk;

    uipi_post_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .tbl_base(tbl_base), .tbl_size(tbl_size), .apic_x2_mode(apic_x2_mode),
        .busy(busy), .done(done), .fault(fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .ipi_req(ipi_req), .ipi_vector(ipi_vector), .ipi_dest(ipi_dest), .ipi_ack(ipi_ack)
    );

    // memory and controller responders, driven on the falling edge
    always @(negedge clk) begin
        if (mem_req) begin
            mem_ready = (($urandom % 4) != 0);
            mem_rdata = bmem[mem_addr[10:3]];
            if (mem_ready) begin
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_wdata;
                    log_we[log_n]   = mem_we;
                    log_lock[log_n] = mem_lock;
                end
                log_n++;
                if (mem_we) bmem[mem_addr[10:3]] = mem_wdata;
            end
        end else begin
            mem_ready = 1'b0;
        end
        if (ipi_req) begin
            ipi_ack = (($urandom % 2) != 0);
            if (ipi_ack) begin
                ipi_n++;
                ipi_vec_seen  = ipi_vector;
                ipi_dst_seen  = ipi_dest;
                ipi_lock_seen = mem_lock;
            end
        end else begin
            ipi_ack = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] slot_word(input logic [5:0] uv);
        return {48'h0, 2'b00, uv, 7'h0, 1'b1};
    endfunction

    function automatic logic [63:0] dsc_word(input logic [31:0] dst, input logic [7:0] nv,
                                             input logic sn, input logic on);
        return {dst, 8'h0, nv, 14'h0, sn, on};
    endfunction

    task automatic put_slot(input int i, input logic [63:0] lo, input logic [63:0] hi);
        bmem[(32'h200 + i*16) >> 3]     = lo;
        bmem[((32'h200 + i*16) >> 3) + 1] = hi;
    endtask

    task automatic put_dsc(input int k, input logic [63:0] lo, input logic [63:0] pend);
        bmem[(32'h400 + k*16) >> 3]     = lo;
        bmem[((32'h400 + k*16) >> 3) + 1] = pend;
    endtask

    task automatic run_op(input logic [63:0] idx, input logic x2, input logic poke);
        logic [63:0] s_addr, s_lo, d_addr, d_lo, d_pend, e_lo, e_pend;
        logic        e_fault, e_ntf;
        int          e_acc;
        logic [31:0] e_dst;
        int          cyc;
        logic        saw_done, saw_fault;
        // expected results from the bench model
        e_fault = 1'b0; e_ntf = 1'b0; e_acc = 6; e_dst = '0;
        s_addr = tbl_base + (idx << 4);
        d_addr = '0; d_lo = '0; d_pend = '0; e_lo = '0; e_pend = '0; s_lo = '0;
        if (idx > tbl_size) begin
            e_fault = 1'b1; e_acc = 0;
        end else begin
            s_lo   = bmem[s_addr[10:3]];
            d_addr = bmem[s_addr[10:3] + 8'd1];
            if (!(s_lo[0] && s_lo[7:1] == 7'h0)) begin
                e_fault = 1'b1; e_acc = 2;
            end else begin
                d_lo   = bmem[d_addr[10:3]];
                d_pend = bmem[d_addr[10:3] + 8'd1];
                if (d_lo[15:2] != 14'h0 || d_lo[31:24] != 8'h0) begin
                    e_fault = 1'b1; e_acc = 3;
                end else begin
                    e_pend = d_pend | (64'd1 << s_lo[13:8]);
                    e_ntf  = !d_lo[1] && !d_lo[0];
                    e_lo   = d_lo | {63'h0, e_ntf};
                    e_dst  = x2 ? d_lo[63:32] : {24'h0, d_lo[47:40]};
                end
            end
        end
        log_n = 0; ipi_n = 0; ipi_lock_seen = 1'b1;
        // issue
        cmd_valid = 1'b1; cmd_index = idx; apic_x2_mode = x2;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_index = '0;
        chk("R10", "busy after accept", {63'h0, busy}, 64'd1);
        saw_done = 1'b0; saw_fault = 1'b0;
        for (cyc = 0; cyc < 400; cyc++) begin
            if (done || fault) begin
                saw_done = done; saw_fault = fault;
                break;
            end
            if (poke && cyc == 2) begin cmd_valid = 1'b1; cmd_index = 64'd0; end
            if (poke && cyc == 3) cmd_valid = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk("R10", "pulse seen", {63'h0, saw_done | saw_fault}, 64'd1);
        chk(e_fault ? "R2" : "R7", "fault flag", {63'h0, saw_fault}, {63'h0, e_fault});
        chk("R10", "done flag", {63'h0, saw_done}, {63'h0, !e_fault});
        @(negedge clk);
        chk("R10", "busy after pulse", {63'h0, busy}, 64'd0);
        chk("R5", "lock after pulse", {63'h0, mem_lock}, 64'd0);
        chk(e_acc == 0 ? "R2" : (e_acc == 2 ? "R4" : (e_acc == 3 ? "R5" : "R6")),
            "access count", 64'(log_n), 64'(e_acc));
        if (e_acc >= 2 && log_n >= 2) begin
            chk("R3", "slot lo addr", log_addr[0], s_addr);
            chk("R3", "slot hi addr", log_addr[1], s_addr + 64'd8);
            chk("R3", "slot unlocked read", {62'h0, log_lock[0] | log_lock[1], log_we[0] | log_we[1]}, 64'd0);
        end
        if (e_acc >= 3 && log_n >= 3) begin
            chk("R5", "desc lo addr", log_addr[2], d_addr);
            chk("R5", "desc lo locked read", {62'h0, log_lock[2], log_we[2]}, 64'd2);
        end
        if (e_acc == 6 && log_n == 6) begin
            chk("R6", "pend read locked", {62'h0, log_lock[3], log_we[3]}, 64'd2);
            chk("R6", "pend write addr", log_addr[4], d_addr + 64'd8);
            chk("R6", "pend write data", log_data[4], e_pend);
            chk("R6", "pend write locked", {62'h0, log_lock[4], log_we[4]}, 64'd3);
            chk("R7", "lo write addr", log_addr[5], d_addr);
            chk("R7", "lo write data", log_data[5], e_lo);
            chk("R6", "pend in memory", bmem[d_addr[10:3] + 8'd1], e_pend);
        end
        chk("R7", "notify count", 64'(ipi_n), {63'h0, e_ntf});
        if (e_ntf && ipi_n == 1) begin
            chk("R9", "vector", {56'h0, ipi_vec_seen}, {56'h0, d_lo[23:16]});
            chk("R9", "dest", {32'h0, ipi_dst_seen}, {32'h0, e_dst});
            chk("R8", "lock at notify", {63'h0, ipi_lock_seen}, 64'd0);
        end
        if (poke) begin
            @(negedge clk);
            chk("R10", "no restart after ignored cmd", {62'h0, busy, mem_req}, 64'd0);
        end
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", {58'h0, busy, mem_req, mem_lock, ipi_req, done, fault}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {58'h0, busy, mem_req, mem_lock, ipi_req, done, fault}, 64'd0);

        // directed corner cases
        put_slot(0, slot_word(6'd63), 64'h400);
        put_dsc(0, dsc_word(32'hA1B2C3D4, 8'hE5, 1'b0, 1'b0), 64'h0);
        run_op(64'd6, 1'b1, 1'b0);                       // R2 just past the limit
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);     // R2 far past the limit
        run_op(64'd0, 1'b1, 1'b0);                       // R7 notify, R9 wide dest, top bit
        run_op(64'd0, 1'b1, 1'b0);                       // R7 outstanding already set
        put_slot(5, slot_word(6'd0), 64'h410);
        put_dsc(1, dsc_word(32'h0000_5A00, 8'h31, 1'b0, 1'b0), 64'h8000_0000_0000_0000);
        run_op(64'd5, 1'b0, 1'b0);                       // R2 boundary, R9 narrow dest
        put_slot(1, slot_word(6'd3) & ~64'd1, 64'h420);
        run_op(64'd1, 1'b0, 1'b0);                       // R4 not valid
        put_slot(2, slot_word(6'd3) | 64'h8, 64'h420);
        run_op(64'd2, 1'b0, 1'b0);                       // R4 reserved slot bit
        put_slot(3, slot_word(6'd4), 64'h430);
        put_dsc(3, dsc_word(32'h1, 8'h2, 1'b0, 1'b0) | 64'h4, 64'h0);
        run_op(64'd3, 1'b0, 1'b0);                       // R5 reserved bit 2
        put_dsc(3, dsc_word(32'h1, 8'h2, 1'b0, 1'b0) | 64'h8000_0000, 64'h0);
        run_op(64'd3, 1'b1, 1'b0);                       // R5 reserved bit 31
        put_slot(4, slot_word(6'd17), 64'h440);
        put_dsc(4, dsc_word(32'h77, 8'h99, 1'b1, 1'b0), 64'h0);
        run_op(64'd4, 1'b1, 1'b0);                       // R7 suppressed
        put_dsc(4, dsc_word(32'h1234_5678, 8'h40, 1'b0, 1'b0), 64'h0);
        run_op(64'd4, 1'b0, 1'b1);                       // R10 command ignored while busy

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < 6; i++) begin
                logic [63:0] lo;
                lo = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_3F00;
                lo = lo | 64'd1;
                if (($urandom % 4) == 0) lo = lo ^ (64'd1 << ($urandom % 8));
                put_slot(i, lo, 64'h400 + 64'(($urandom % 8) * 16));
            end
            for (int k = 0; k < 8; k++) begin
                logic [63:0] lo;
                lo = dsc_word($urandom, 8'($urandom), 1'($urandom), 1'($urandom));
                if (($urandom % 4) == 0) begin
                    if (($urandom % 2) == 0) lo = lo | (64'd1 << (2 + ($urandom % 14)));
                    else lo = lo | (64'd1 << (24 + ($urandom % 8)));
                end
                put_dsc(k, lo, {$urandom, $urandom});
            end
            run_op(64'($urandom % 8), 1'($urandom), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule